// File: doc/BRIEF.md
# Programmable Shift-Add Coefficient Multiplier

This block multiplies a signed sample by a signed coefficient that can change on every cycle. It uses no general multiplier. The sample is first turned into a magnitude-like value by a fixed XOR stage with no multiplexer. A small shared network of three adders then builds every multiple from zero to seven of that value.

The coefficient magnitude is cut into 3-bit digits. Each digit picks one of the eight multiples. The picked terms are weighted by their digit position and summed by a chain of zero-gated adders. A final adder folds in a correction term that the one's-complement input step needs, and the sign is put back with an XOR and a carry-in of one.

The block is a two-stage pipeline, and a valid flag travels alongside the data. Coefficient storage and the surrounding filter structure sit outside the block.

Top module: `coef_mult_shiftadd`

## Requirements
- R1: For every sample in -128..127 and every coefficient, `product` equals sample × (coef_neg ? -coef_mag : coef_mag). It is written as exact 17-bit two's complement, and this includes the most negative sample.
- R2: The partial-product network delivers k × u for every k in 0..7, where u is the sample after the input sign stage.
- R3: Coefficient magnitude bits [3k+2:3k] form digit k. Digit k has weight 8^k, for k = 0, 1, 2.
- R4: A zero digit adds nothing to the result, so its adder passes the running sum through. A zero magnitude gives a product of 0 whatever the coefficient sign.
- R5: A sample of 0 gives a product of 0. A coefficient of sign 1 with magnitude 0 also gives 0.
- R6: When `in_valid` is high at a clock edge, `out_valid` is high after the second following edge, and `product` then holds that operand pair's result.
- R7: When `in_valid` is low at an edge, `out_valid` is low two edges later. `product` keeps its previous value in every cycle in which `out_valid` is low.
- R8: While `rst_n` is low, `out_valid` is 0 and `product` is 0.
- R9: When both the sample and the magnitude are nonzero, bit 16 of `product` equals the XOR of the sample sign bit and `coef_neg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `sample`, `coef_neg` and `coef_mag` are valid |
| sample | input | 8 | Two's-complement input sample |
| coef_neg | input | 1 | Coefficient sign, 1 = negative |
| coef_mag | input | 9 | Coefficient magnitude, three 3-bit digits |
| out_valid | output | 1 | `product` carries a new result |
| product | output | 17 | Two's-complement product |

## Verification
The assertions watch the following on every cycle:
- the two-cycle valid timing and the holding of `product` during idle cycles;
- the zero results for a zero sample or zero magnitude;
- the sign bit of nonzero products;
- each shared multiple against a behavioural multiply;
- the agreement between each zero-digit flag and its selected term.

Exact product values need the bench's sweeps. These cover every sample against every low-digit multiple, every coefficient value against edge and pseudo-random samples, single-digit coefficients that expose the digit weights, and idle cycles placed between valid operands.

// File: rtl/cm_pkg.sv
package cm_pkg;

   // digit width of the coefficient magnitude; the partial-product network is built for 3
   localparam int unsigned CM_DIGIT_W  = 3;
   localparam int unsigned CM_NUM_MULT = 1 << CM_DIGIT_W;

   typedef logic [CM_DIGIT_W-1:0] cm_digit_t;

endpackage

// File: rtl/cm_sign_conv.sv
module cm_sign_conv #(
   parameter int unsigned W            = 8,
   parameter bit          INJECT_CARRY = 1'b0
) (
   input  logic [W-1:0] din,
   input  logic         neg,
   output logic [W-1:0] dout
);

   if (W < 2) begin : g_bad_w
      $error("cm_sign_conv: W must be at least 2");
   end

   logic [W-1:0] flipped;

   // fixed XOR datapath: no selection between true and inverted data
   assign flipped = din ^ {W{neg}};

   if (INJECT_CARRY) begin : g_carry
      // +1 enters as the carry-in, completing a two's-complement negation
      assign dout = flipped + {{(W-1){1'b0}}, neg};
   end else begin : g_plain
      assign dout = flipped;
   end

endmodule

// File: rtl/cm_ppg.sv
module cm_ppg
   import cm_pkg::*;
#(
   parameter int unsigned IN_W       = 8,
   parameter bit          SHARED_CSE = 1'b1,
   localparam int unsigned OUT_W     = IN_W + CM_DIGIT_W
) (
   input  logic [IN_W-1:0]                    din,
   output logic [CM_NUM_MULT-1:0][OUT_W-1:0]  mult
);

   if (CM_DIGIT_W != 3) begin : g_bad_digit
      $error("cm_ppg: network is laid out for 3-bit digits");
   end

   logic [OUT_W-1:0] x1, x2, x4;
   logic [OUT_W-1:0] s3, s5, s6, s7;

   assign x1 = OUT_W'(din);
   assign x2 = x1 << 1;
   assign x4 = x1 << 2;

   if (SHARED_CSE) begin : g_shared
      // three adders in total: 6x and 3x share one sum, 7x reuses it
      assign s3 = x1 + x2;
      assign s5 = x1 + x4;
      assign s6 = s3 << 1;
      assign s7 = s6 + x1;
   end else begin : g_direct
      // each multiple built on its own from its set bits
      assign s3 = x1 + x2;
      assign s5 = x1 + x4;
      assign s6 = x2 + x4;
      assign s7 = x1 + x2 + x4;
   end

   always_comb begin
      mult[0] = '0;
      mult[1] = x1;
      mult[2] = x2;
      mult[3] = s3;
      mult[4] = x4;
      mult[5] = s5;
      mult[6] = s6;
      mult[7] = s7;
   end

   // R2: every precomputed multiple matches a behavioural multiply
   always_comb begin
      for (int k = 0; k < int'(CM_NUM_MULT); k++) begin
         assert_ppg_multiple_R2: assert (mult[k] == OUT_W'(k) * x1)
            else $error("ppg multiple %0d wrong", k);
      end
   end

endmodule

// File: rtl/cm_digit_mux.sv
module cm_digit_mux
   import cm_pkg::*;
#(
   parameter int unsigned W = 11
) (
   input  logic [CM_NUM_MULT-1:0][W-1:0] mult,
   input  cm_digit_t                     digit,
   output logic [W-1:0]                  term,
   output logic                          is_zero
);

   assign term    = mult[digit];
   // equality check used to gate the downstream adder
   assign is_zero = (digit == '0);

endmodule

// File: rtl/cm_ctrl_adder.sv
module cm_ctrl_adder #(
   parameter int unsigned W = 17
) (
   input  logic [W-1:0] acc,
   input  logic [W-1:0] term,
   input  logic         term_zero,
   output logic [W-1:0] sum
);

   // a zero digit bypasses the adder and forwards the running sum
   assign sum = term_zero ? acc : acc + term;

   // R4: the control flag and the selected term come from separate logic and must agree
   always_comb begin
      if (term_zero) begin
         assert_zero_flag_term_R4: assert (term == '0)
            else $error("zero flag set with nonzero term");
      end
   end

endmodule

// File: rtl/coef_mult_shiftadd.sv
module coef_mult_shiftadd
   import cm_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 8,
   parameter int unsigned NUM_DIGITS = 3,
   parameter bit          SHARED_PPG = 1'b1,
   localparam int unsigned MAG_W     = CM_DIGIT_W * NUM_DIGITS,
   localparam int unsigned PROD_W    = SAMPLE_W + MAG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                coef_neg,
   input  logic [MAG_W-1:0]    coef_mag,
   output logic                out_valid,
   output logic [PROD_W-1:0]   product
);

   localparam int unsigned MULT_W = SAMPLE_W + CM_DIGIT_W;
   localparam int unsigned ACC_W  = PROD_W;

   if (NUM_DIGITS < 2) begin : g_bad_digits
      $error("coef_mult_shiftadd: NUM_DIGITS must be at least 2");
   end
   if (SAMPLE_W < 2) begin : g_bad_sample
      $error("coef_mult_shiftadd: SAMPLE_W must be at least 2");
   end

   // ---------------- stage 1: sign conversion, multiples, digit selection
   logic                                sample_neg;
   logic [SAMPLE_W-1:0]                 conv;
   logic [CM_NUM_MULT-1:0][MULT_W-1:0]  mult;
   logic [NUM_DIGITS-1:0][MULT_W-1:0]   term_c;
   logic [NUM_DIGITS-1:0]               zero_c;
   logic [MAG_W-1:0]                    corr_c;
   logic                                neg_c;

   assign sample_neg = sample[SAMPLE_W-1];
   assign neg_c      = sample_neg ^ coef_neg;
   // one's complement leaves |x|-1 for negative x; the lost magnitude is added back later
   assign corr_c     = coef_mag & {MAG_W{sample_neg}};

   cm_sign_conv #(.W(SAMPLE_W), .INJECT_CARRY(1'b0)) u_in_conv (
      .din  (sample),
      .neg  (sample_neg),
      .dout (conv)
   );

   cm_ppg #(.IN_W(SAMPLE_W), .SHARED_CSE(SHARED_PPG)) u_ppg (
      .din  (conv),
      .mult (mult)
   );

   for (genvar k = 0; k < int'(NUM_DIGITS); k++) begin : g_digit
      cm_digit_mux #(.W(MULT_W)) u_mux (
         .mult    (mult),
         .digit   (coef_mag[k*CM_DIGIT_W +: CM_DIGIT_W]),
         .term    (term_c[k]),
         .is_zero (zero_c[k])
      );
   end

   logic                              v1;
   logic [NUM_DIGITS-1:0][MULT_W-1:0] term_q;
   logic [NUM_DIGITS-1:0]             zero_q;
   logic [MAG_W-1:0]                  corr_q;
   logic                              neg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1     <= 1'b0;
         term_q <= '0;
         zero_q <= '1;
         corr_q <= '0;
         neg_q  <= 1'b0;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            term_q <= term_c;
            zero_q <= zero_c;
            corr_q <= corr_c;
            neg_q  <= neg_c;
         end
      end
   end

   // ---------------- stage 2: controlled adder layers, final add, sign restore
   logic [NUM_DIGITS-1:0][ACC_W-1:0] acc;
   logic [ACC_W-1:0]                 mag_sum;
   logic [PROD_W-1:0]                prod_c;

   assign acc[0] = ACC_W'(term_q[0]);

   for (genvar k = 1; k < int'(NUM_DIGITS); k++) begin : g_layer
      logic [ACC_W-1:0] weighted;
      assign weighted = ACC_W'(term_q[k]) << (CM_DIGIT_W * k);

      cm_ctrl_adder #(.W(ACC_W)) u_add (
         .acc       (acc[k-1]),
         .term      (weighted),
         .term_zero (zero_q[k]),
         .sum       (acc[k])
      );
   end

   assign mag_sum = acc[NUM_DIGITS-1] + ACC_W'(corr_q);

   cm_sign_conv #(.W(PROD_W), .INJECT_CARRY(1'b1)) u_out_conv (
      .din  (mag_sum),
      .neg  (neg_q),
      .dout (prod_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         product   <= '0;
      end else begin
         out_valid <= v1;
         if (v1) begin
            product <= prod_c;
         end
      end
   end

   // ---------------- assertions
   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(product));

   assert_zero_coef_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && coef_mag == '0) |-> ##2 (product == '0));

   assert_zero_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sample == '0) |-> ##2 (product == '0));

   assert_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sample != '0 && coef_mag != '0) |-> ##2
      (product[PROD_W-1] == $past(sample[SAMPLE_W-1] ^ coef_neg, 2)));

endmodule

// File: tb/coef_mult_shiftadd_tb_top.sv
module coef_mult_shiftadd_tb_top;

   localparam int SW = 8;
   localparam int MW = 9;
   localparam int PW = 17;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [SW-1:0] sample;
   logic          coef_neg;
   logic [MW-1:0] coef_mag;
   logic          out_valid;
   logic [PW-1:0] product;

   always #5 clk = ~clk;

   coef_mult_shiftadd dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .sample    (sample),
      .coef_neg  (coef_neg),
      .coef_mag  (coef_mag),
      .out_valid (out_valid),
      .product   (product)
   );

   int    checks = 0;
   int    errors = 0;
   bit    hv0 = 0, hv1 = 0;
   int    he0 = 0, he1 = 0;
   string ht0 = "", ht1 = "";
   int    last_prod = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'($signed(lfsr[7:0]));
   endfunction

   // checks the pair driven two steps earlier, then drives a new one
   task automatic step(bit v, int s, bit n, int m, string tag);
      int e;
      int act;
      @(negedge clk);
      act = int'($signed(product));
      if (hv1) begin
         check("R6 out_valid", int'(out_valid), 1);
         check(ht1, act, he1);
         if (he1 != 0) check("R9 sign", int'(product[PW-1]), int'(he1 < 0));
         last_prod = he1;
      end else begin
         check("R7 out_valid low", int'(out_valid), 0);
         check("R7 hold", act, last_prod);
      end
      e   = s * (n ? -m : m);
      hv1 = hv0; he1 = he0; ht1 = ht0;
      hv0 = v;   he0 = e;   ht0 = tag;
      in_valid = v;
      sample   = SW'(s);
      coef_neg = n;
      coef_mag = MW'(m);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int edge_s [5] = '{-128, -1, 1, 127, 0};
      rst_n = 1'b0; in_valid = 1'b0; sample = '0; coef_neg = 1'b0; coef_mag = '0;
      // R8: reset state
      repeat (3) begin
         @(negedge clk);
         check("R8 out_valid", int'(out_valid), 0);
         check("R8 product", int'($signed(product)), 0);
      end
      rst_n = 1'b1;

      // R2: every sample against every single multiple 0..7
      for (int m = 0; m < 8; m++)
         for (int s = -128; s < 128; s++)
            step(1, s, m[0], m, "R2 multiple");

      // R3: single nonzero digit at each position
      for (int k = 0; k < 3; k++)
         for (int d = 1; d < 8; d++) begin
            for (int i = 0; i < 4; i++) step(1, edge_s[i], 1'b0, d << (3 * k), "R3 digit weight");
            step(1, next_rand(), 1'b1, d << (3 * k), "R3 digit weight");
            step(1, next_rand(), 1'b0, d << (3 * k), "R3 digit weight");
         end

      // R4: zero magnitude and zero middle/low digits
      for (int i = 0; i < 5; i++) begin
         step(1, edge_s[i], 1'b0, 0, "R4 zero magnitude");
         step(1, edge_s[i], 1'b1, 0, "R4 zero magnitude");
         step(1, edge_s[i], 1'b1, 327, "R4 zero middle digit");
         step(1, edge_s[i], 1'b0, 56, "R4 zero outer digits");
         step(1, edge_s[i], 1'b1, 448, "R4 zero low digits");
      end

      // R5: zero sample, including sign-1 zero coefficient
      for (int m = 0; m < 512; m += 37) begin
         step(1, 0, 1'b0, m, "R5 zero sample");
         step(1, 0, 1'b1, m, "R5 zero sample");
      end
      step(1, -77, 1'b1, 0, "R5 negative zero coef");

      // R1: every coefficient value with edge and random samples; idle gaps for R7
      for (int n = 0; n < 2; n++)
         for (int m = 0; m < 512; m++) begin
            for (int i = 0; i < 5; i++) step(1, edge_s[i], n[0], m, "R1 product");
            step(1, next_rand(), n[0], m, "R1 product");
            step(1, next_rand(), n[0], m, "R1 product");
            if (m % 5 == 0) step(0, next_rand(), n[0], 511 - m, "R7 idle");
         end

      // back-to-back idle run then flush
      step(1, -128, 1'b1, 511, "R1 corner");
      step(1, -128, 1'b0, 511, "R1 corner");
      step(0, 5, 1'b0, 5, "R7 idle");
      step(0, 9, 1'b1, 9, "R7 idle");
      step(0, 0, 1'b0, 0, "R7 idle");
      step(0, 0, 1'b0, 0, "R7 idle");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule